// File: doc/BRIEF.md
# Fault response controller

This block takes one raw fault-detect signal, for example the output of a current-limit comparator, and decides what the gate driver must do about it. The signal is first filtered: it has to stay high for a chosen number of timebase ticks before it counts as a fault. The accepted fault then runs one of several responses, chosen by a 4-bit mode code. The block can latch the fault until software clears it, or release it by itself after a retry interval. It can also only report the fault, or ignore the input entirely.

While a fault is in force the block drives an active-low fault flag and asks for one gate-driver action: tristate all switches, or turn on every low-side switch to brake. A timebase tick with a 0.1 ms period counts all times. Fixed tables convert the 4-bit deglitch code, the 4-bit retry-time code and the 3-bit attempt-limit code into tick counts. An attempt counter bounds the automatic retries. When the limit is used up, the next fault latches.

Top module: `fault_response_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no fault, `nfault_o` is 1 and `tristate_o` and `brake_o` are 0.
- R2: Mode codes 0 and 1 latch an accepted fault with `tristate_o`=1. Codes 2 and 3 latch it with `brake_o`=1. In both cases `nfault_o`=0, and the fault stays after the raw input drops until `clear_i` is pulsed. The outputs release on the clock after that pulse.
- R3: Mode codes 4 and 5 answer an accepted fault with `tristate_o`=1, and codes 6 and 7 with `brake_o`=1, each with `nfault_o`=0. The fault then releases by itself when the retry interval has elapsed.
- R4: The retry interval in ticks is 3000 for code 0 and 5000 for code 1. Codes 2 to 15 give (code-1)*10000. A retry holds its outputs for exactly that many ticks.
- R5: The attempt-limit code maps 0 to no limit, and 1 to 7 to 2, 3, 5, 7, 10, 15 and 20 attempts. A fault accepted in a retry mode after the limit is used up latches with the mode's action.
- R6: Mode code 8 drives `nfault_o`=0 only while the filtered fault is present, and never asserts `tristate_o` or `brake_o`.
- R7: Mode codes 9 to 15 ignore the raw input. All outputs stay inactive.
- R8: The deglitch code maps to 0, 1, 2, 5, 10, 25, 50, 75, 100, 250, 500, 750, 1000, 2000, 5000 and 10000 ticks for codes 0 to 15. The raw input must stay high that many ticks without a break, and any low cycle restarts the count.
- R9: `tristate_o` and `brake_o` are never 1 in the same cycle.
- R10: The attempt count returns to zero when `clear_i` is pulsed, or when one full retry interval passes in the idle state with no accepted fault.
- R11: With deglitch code 0, the outputs change on the first clock edge at which the raw input is sampled high and `tick_i` is present or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase pulse, one clock wide, 0.1 ms period |
| fault_raw_i | input | 1 | Raw fault-detect signal |
| mode_i | input | 4 | Response mode code |
| deg_code_i | input | 4 | Deglitch time code |
| retry_code_i | input | 4 | Retry interval code |
| limit_code_i | input | 3 | Attempt-limit code |
| clear_i | input | 1 | Software clear pulse |
| nfault_o | output | 1 | Active-low fault flag |
| tristate_o | output | 1 | Request to tristate the gate driver |
| brake_o | output | 1 | Request to turn on all low-side switches |

## Verification
A stuck or miscounted interval timer shows as a retry window one or more cycles too long or too short. An idle-time timer that never expires shows one retry later, when a fault that should have retried latches instead. A wrong attempt count shows only on the fault that crosses the limit, which can come several thousand cycles after the error. Wrong deglitch state shows as a fault accepted a tick early, or after a break in the raw signal. The reference model is compared on every clock, so each of these errors is caught on the first cycle where the outputs differ.

// File: rtl/frc_pkg.sv
package frc_pkg;

   localparam int MODE_W  = 4;
   localparam int CODE_W  = 4;
   localparam int LIMIT_W = 3;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_RETRY  = 2'd1,
      ST_LATCH  = 2'd2,
      ST_REPORT = 2'd3
   } frc_state_e;

   typedef enum logic {
      ACT_TRISTATE = 1'b0,
      ACT_BRAKE    = 1'b1
   } frc_act_e;

   // qualification time in 0.1 ms ticks
   function automatic int unsigned deglitch_ticks(input logic [CODE_W-1:0] code);
      case (code)
         4'd0:    return 0;
         4'd1:    return 1;
         4'd2:    return 2;
         4'd3:    return 5;
         4'd4:    return 10;
         4'd5:    return 25;
         4'd6:    return 50;
         4'd7:    return 75;
         4'd8:    return 100;
         4'd9:    return 250;
         4'd10:   return 500;
         4'd11:   return 750;
         4'd12:   return 1000;
         4'd13:   return 2000;
         4'd14:   return 5000;
         default: return 10000;
      endcase
   endfunction

   // retry interval in 0.1 ms ticks
   function automatic int unsigned retry_ticks(input logic [CODE_W-1:0] code);
      if (code == 4'd0)
         return 3000;
      else if (code == 4'd1)
         return 5000;
      else
         return (int'(code) - 1) * 10000;
   endfunction

   // allowed automatic retries, 0 = unbounded
   function automatic int unsigned attempt_limit(input logic [LIMIT_W-1:0] code);
      case (code)
         3'd0:    return 0;
         3'd1:    return 2;
         3'd2:    return 3;
         3'd3:    return 5;
         3'd4:    return 7;
         3'd5:    return 10;
         3'd6:    return 15;
         default: return 20;
      endcase
   endfunction

endpackage

// File: rtl/frc_deglitch.sv
module frc_deglitch #(
   parameter int DEG_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             raw_i,
   input  logic [DEG_W-1:0] hold_i,
   output logic             qual_o
);

   logic [DEG_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (!raw_i)
         run_q <= '0;
      else if (tick_i && (run_q < hold_i))
         run_q <= run_q + 1'b1;
   end

   assign qual_o = raw_i && (run_q >= hold_i);

   // a filtered fault with a nonzero hold time needs the raw input high on the previous cycle too
   AST_QUAL_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
      (qual_o && (hold_i != '0)) |-> $past(raw_i)); // R8

endmodule

// File: rtl/frc_interval.sv
module frc_interval #(
   parameter int RT_W = 18
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            clr_i,
   input  logic [RT_W-1:0] span_i,
   output logic            done_o
);

   logic [RT_W-1:0] elapsed_q;
   logic [RT_W-1:0] last_step;

   assign last_step = span_i - RT_W'(1);
   assign done_o    = tick_i && (elapsed_q >= last_step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         elapsed_q <= '0;
      else if (clr_i)
         elapsed_q <= '0;
      else if (tick_i)
         elapsed_q <= done_o ? '0 : elapsed_q + 1'b1;
   end

endmodule

// File: rtl/frc_fsm.sv
module frc_fsm
   import frc_pkg::*;
#(
   parameter int ATT_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 qual_i,
   input  logic                 clear_i,
   input  logic [MODE_W-1:0]    mode_i,
   input  logic [ATT_W-1:0]     limit_i,
   input  logic                 tmr_done_i,
   output logic                 tmr_clr_o,
   output frc_state_e           state_o,
   output frc_act_e             act_o
);

   localparam logic [ATT_W-1:0] ATT_MAX = {ATT_W{1'b1}};

   frc_state_e       state_q, state_d;
   frc_act_e         act_q, act_d;
   logic [ATT_W-1:0] att_q, att_d;
   logic             may_retry;

   assign may_retry = (limit_i == '0) || (att_q < limit_i);

   always_comb begin
      state_d = state_q;
      act_d   = act_q;
      att_d   = att_q;
      if (clear_i) begin
         state_d = ST_IDLE;
         att_d   = '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (qual_i && (mode_i <= 4'd8)) begin
                  if (mode_i[3]) begin
                     state_d = ST_REPORT;
                  end else begin
                     act_d = mode_i[1] ? ACT_BRAKE : ACT_TRISTATE;
                     if (!mode_i[2]) begin
                        state_d = ST_LATCH;
                     end else if (may_retry) begin
                        state_d = ST_RETRY;
                        if (att_q != ATT_MAX)
                           att_d = att_q + 1'b1;
                     end else begin
                        state_d = ST_LATCH;
                     end
                  end
               end else if (tmr_done_i) begin
                  att_d = '0;
               end
            end
            ST_RETRY:  if (tmr_done_i) state_d = ST_IDLE;
            ST_LATCH:  state_d = ST_LATCH;
            ST_REPORT: if (!qual_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
         endcase
      end
   end

   // one counter serves both the retry hold time and the idle quiet time
   assign tmr_clr_o = clear_i || (state_d != state_q) ||
                      (state_q == ST_LATCH) || (state_q == ST_REPORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         act_q   <= ACT_TRISTATE;
         att_q   <= '0;
      end else begin
         state_q <= state_d;
         act_q   <= act_d;
         att_q   <= att_d;
      end
   end

   assign state_o = state_q;
   assign act_o   = act_q;

   AST_LATCH_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LATCH && !clear_i) |=> (state_q == ST_LATCH)); // R2

   AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (state_q == ST_IDLE)); // R2

   AST_RETRY_HELD_UNTIL_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RETRY && !clear_i && !tmr_done_i) |=> (state_q == ST_RETRY)); // R3

   AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && mode_i >= 4'd9) |=> (state_q == ST_IDLE)); // R7

   AST_NO_RETRY_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !clear_i && limit_i != '0 && att_q >= limit_i &&
       qual_i && mode_i[3:2] == 2'b01) |=> (state_q == ST_LATCH)); // R5

   AST_REPORT_FOLLOWS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REPORT && !qual_i) |=> (state_q == ST_IDLE)); // R6

endmodule

// File: rtl/fault_response_ctrl.sv
module fault_response_ctrl
   import frc_pkg::*;
#(
   parameter int DEG_W   = 14,
   parameter int RT_W    = 18,
   parameter int ATT_W   = 5,
   parameter bit OUT_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       fault_raw_i,
   input  logic [3:0] mode_i,
   input  logic [3:0] deg_code_i,
   input  logic [3:0] retry_code_i,
   input  logic [2:0] limit_code_i,
   input  logic       clear_i,
   output logic       nfault_o,
   output logic       tristate_o,
   output logic       brake_o
);

   logic [DEG_W-1:0] hold_ticks;
   logic [RT_W-1:0]  span_ticks;
   logic [ATT_W-1:0] limit_cnt;
   logic             qual;
   logic             tmr_done;
   logic             tmr_clr;
   frc_state_e       state;
   frc_act_e         act;
   logic             drive_on;
   logic             nf_c, tri_c, brk_c;

   assign hold_ticks = DEG_W'(deglitch_ticks(deg_code_i));
   assign span_ticks = RT_W'(retry_ticks(retry_code_i));
   assign limit_cnt  = ATT_W'(attempt_limit(limit_code_i));

   frc_deglitch #(.DEG_W(DEG_W)) i_deglitch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .raw_i  (fault_raw_i),
      .hold_i (hold_ticks),
      .qual_o (qual)
   );

   frc_interval #(.RT_W(RT_W)) i_interval (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .clr_i  (tmr_clr),
      .span_i (span_ticks),
      .done_o (tmr_done)
   );

   frc_fsm #(.ATT_W(ATT_W)) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .qual_i     (qual),
      .clear_i    (clear_i),
      .mode_i     (mode_i),
      .limit_i    (limit_cnt),
      .tmr_done_i (tmr_done),
      .tmr_clr_o  (tmr_clr),
      .state_o    (state),
      .act_o      (act)
   );

   assign drive_on = (state == ST_RETRY) || (state == ST_LATCH);
   assign nf_c     = (state == ST_IDLE);
   assign tri_c    = drive_on && (act == ACT_TRISTATE);
   assign brk_c    = drive_on && (act == ACT_BRAKE);

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               nfault_o   <= 1'b1;
               tristate_o <= 1'b0;
               brake_o    <= 1'b0;
            end else begin
               nfault_o   <= nf_c;
               tristate_o <= tri_c;
               brake_o    <= brk_c;
            end
         end
      end else begin : g_out_comb
         assign nfault_o   = nf_c;
         assign tristate_o = tri_c;
         assign brake_o    = brk_c;
      end
   endgenerate

   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(tristate_o && brake_o)); // R9

   AST_ACTION_FLAGS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (tristate_o || brake_o) |-> !nfault_o); // R2

endmodule

// File: tb/test_fault_response_ctrl.sv
`timescale 1ns/1ps
module test_fault_response_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       fault_raw_i = 1'b0;
   logic [3:0] mode_i = 4'd0;
   logic [3:0] deg_code_i = 4'd0;
   logic [3:0] retry_code_i = 4'd0;
   logic [2:0] limit_code_i = 3'd0;
   logic       clear_i = 1'b0;
   logic       nfault_o, tristate_o, brake_o;

   int checks = 0;
   int fails  = 0;
   int tick_div = 1;
   bit finished = 1'b0;
   bit cmp_en = 1'b0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   fault_response_ctrl i_fault_response_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick_i),
      .fault_raw_i  (fault_raw_i),
      .mode_i       (mode_i),
      .deg_code_i   (deg_code_i),
      .retry_code_i (retry_code_i),
      .limit_code_i (limit_code_i),
      .clear_i      (clear_i),
      .nfault_o     (nfault_o),
      .tristate_o   (tristate_o),
      .brake_o      (brake_o)
   );

   // ---------------- reference tables -----------------
   function automatic int ref_hold(input int c);
      int t [16] = '{0, 1, 2, 5, 10, 25, 50, 75, 100, 250, 500, 750, 1000, 2000, 5000, 10000};
      return t[c];
   endfunction
   function automatic int ref_span(input int c);
      if (c < 2) return (c == 0) ? 3000 : 5000;
      return 10000 * (c - 1);
   endfunction
   function automatic int ref_limit(input int c);
      int t [8] = '{0, 2, 3, 5, 7, 10, 15, 20};
      return t[c];
   endfunction

   // ---------------- behavioural reference model -----------------
   // phase: 0 quiet, 1 auto-retry, 2 held, 3 reporting
   int m_phase = 0, m_brake = 0, m_run = 0, m_elapsed = 0, m_tries = 0;

   always @(posedge clk) begin
      int hold, span, lim, nxt;
      bit good, fin;
      if (!rst_n) begin
         m_phase = 0; m_brake = 0; m_run = 0; m_elapsed = 0; m_tries = 0;
      end else begin
         hold = ref_hold(deg_code_i);
         span = ref_span(retry_code_i);
         lim  = ref_limit(limit_code_i);
         good = fault_raw_i && (m_run >= hold);
         fin  = tick_i && (m_elapsed >= span - 1);
         nxt  = m_phase;
         if (clear_i) begin
            nxt = 0; m_tries = 0;
         end else if (m_phase == 0) begin
            if (good && mode_i == 8) nxt = 3;
            else if (good && mode_i < 8) begin
               m_brake = (mode_i % 4) >= 2;
               if (mode_i < 4) nxt = 2;
               else if (lim == 0 || m_tries < lim) begin
                  nxt = 1;
                  if (m_tries < 31) m_tries++;
               end else nxt = 2;
            end else if (fin) m_tries = 0;
         end else if (m_phase == 1) begin
            if (fin) nxt = 0;
         end else if (m_phase == 3) begin
            if (!good) nxt = 0;
         end
         if (clear_i || nxt != m_phase || m_phase >= 2) m_elapsed = 0;
         else if (tick_i) m_elapsed = fin ? 0 : m_elapsed + 1;
         if (!fault_raw_i) m_run = 0;
         else if (tick_i && m_run < hold) m_run++;
         m_phase = nxt;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      logic [2:0] exp_v, got_v;
      if (cmp_en && !finished) begin
         exp_v = {m_phase == 0, (m_phase == 1 || m_phase == 2) && !m_brake,
                  (m_phase == 1 || m_phase == 2) && m_brake};
         got_v = {nfault_o, tristate_o, brake_o};
         checks++;
         if (got_v !== exp_v) begin
            fails++;
            $display("FAIL %s model compare at %0t: {nfault,tristate,brake} actual %b expected %b",
                     cur_req, $time, got_v, exp_v);
         end
         if (tristate_o && brake_o) begin
            fails++;
            $display("FAIL R9 both actions at %0t: actual 11 expected not both", $time);
         end
      end
   end

   // timebase
   initial begin
      int n = 0;
      forever begin
         @(negedge clk);
         tick_i = (n % tick_div) == 0;
         n++;
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic [2:0] exp_v);
      logic [2:0] got_v;
      got_v = {nfault_o, tristate_o, brake_o};
      checks++;
      if (got_v !== exp_v) begin
         fails++;
         $display("FAIL %s %s: {nfault,tristate,brake} actual %b expected %b", req, what, got_v, exp_v);
      end
   endtask

   task automatic pulse_fault();
      fault_raw_i = 1'b1;
      step(1);
      fault_raw_i = 1'b0;
   endtask

   task automatic do_clear();
      clear_i = 1'b1;
      step(1);
      clear_i = 1'b0;
      step(1);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, actual running expected done");
      finish_run();
   end

   initial begin
      // R1: reset state
      step(1);
      chk("R1", "during reset", 3'b100);
      step(2);
      rst_n = 1'b1;
      step(2);
      chk("R1", "after reset", 3'b100);
      cmp_en = 1'b1;

      // R8: two-tick deglitch, single-cycle glitch rejected
      cur_req = "R8";
      mode_i = 4'd0; deg_code_i = 4'd2;
      pulse_fault();
      step(4);
      chk("R8", "glitch rejected", 3'b100);
      // R2 / R8: held fault accepted after two ticks, latched tristate
      fault_raw_i = 1'b1;
      step(2);
      chk("R8", "not yet accepted", 3'b100);
      step(1);
      chk("R2", "latched tristate", 3'b010);
      fault_raw_i = 1'b0;
      step(20);
      chk("R2", "latch holds after raw drops", 3'b010);
      clear_i = 1'b1;
      step(1);
      clear_i = 1'b0;
      chk("R2", "released by clear", 3'b100);

      // R11 / R2: no deglitch, brake latch on the next edge
      cur_req = "R11";
      mode_i = 4'd3; deg_code_i = 4'd0;
      fault_raw_i = 1'b1;
      step(1);
      chk("R11", "brake latched one edge later", 3'b001);
      fault_raw_i = 1'b0;
      step(3);
      do_clear();

      // R8: ten-tick deglitch
      cur_req = "R8";
      mode_i = 4'd1; deg_code_i = 4'd4;
      fault_raw_i = 1'b1;
      step(10);
      chk("R8", "ten ticks not yet accepted", 3'b100);
      step(1);
      chk("R8", "accepted after ten ticks", 3'b010);
      fault_raw_i = 1'b0;
      do_clear();

      // R3 / R5: tristate retry, limit code 1 = two attempts, then latch
      cur_req = "R5";
      mode_i = 4'd5; deg_code_i = 4'd0; retry_code_i = 4'd0; limit_code_i = 3'd1;
      fault_raw_i = 1'b1;
      step(1);
      chk("R3", "first retry tristate", 3'b010);
      step(2999);
      chk("R4", "last cycle of 3000-tick retry", 3'b010);
      step(1);
      chk("R3", "auto-released", 3'b100);
      step(1);
      chk("R5", "second retry", 3'b010);
      step(3000);
      chk("R5", "second release", 3'b100);
      step(1);
      chk("R5", "third fault latches", 3'b010);
      fault_raw_i = 1'b0;
      step(3100);
      chk("R5", "latch persists past retry time", 3'b010);
      do_clear();

      // R3 / R5: brake retry, unlimited attempts
      cur_req = "R3";
      mode_i = 4'd6; limit_code_i = 3'd0;
      fault_raw_i = 1'b1;
      step(3000);
      chk("R3", "brake retry held", 3'b001);
      step(1);
      chk("R3", "brake retry released", 3'b100);
      step(9003);
      chk("R5", "unlimited: fourth release", 3'b100);
      step(1);
      chk("R5", "unlimited: fifth retry", 3'b001);
      fault_raw_i = 1'b0;
      do_clear();

      // R10: quiet interval resets the attempt count
      cur_req = "R10";
      mode_i = 4'd4; limit_code_i = 3'd1;
      pulse_fault();
      step(3000 + 3200);
      pulse_fault();
      step(3000 + 3200);
      pulse_fault();
      chk("R10", "third spaced fault still retries", 3'b010);
      step(3000);
      chk("R10", "third spaced fault releases", 3'b100);
      // R10: clear resets the attempt count
      do_clear();
      pulse_fault();
      step(3000);
      pulse_fault();
      step(3000);
      chk("R10", "two close retries done", 3'b100);
      do_clear();
      pulse_fault();
      chk("R10", "after clear fault retries", 3'b010);
      step(3000);
      chk("R10", "after clear retry releases", 3'b100);
      do_clear();

      // R4: code 2 = 10000 ticks
      cur_req = "R4";
      retry_code_i = 4'd2; limit_code_i = 3'd0;
      pulse_fault();
      step(9999);
      chk("R4", "10000-tick retry still held", 3'b010);
      step(1);
      chk("R4", "10000-tick retry released", 3'b100);
      retry_code_i = 4'd0;
      do_clear();

      // R6: report only
      cur_req = "R6";
      mode_i = 4'd8;
      fault_raw_i = 1'b1;
      step(1);
      chk("R6", "report flags without action", 3'b000);
      step(5);
      chk("R6", "report persists", 3'b000);
      fault_raw_i = 1'b0;
      step(1);
      chk("R6", "report follows fault away", 3'b100);

      // R7: disabled codes
      cur_req = "R7";
      mode_i = 4'd12;
      fault_raw_i = 1'b1;
      step(20);
      chk("R7", "code 12 ignores fault", 3'b100);
      mode_i = 4'd9;
      step(20);
      chk("R7", "code 9 ignores fault", 3'b100);
      fault_raw_i = 1'b0;
      step(2);

      // R8: slow tick, break in the raw input restarts the count
      cur_req = "R8";
      tick_div = 4; mode_i = 4'd0; deg_code_i = 4'd3;
      step(4);
      fault_raw_i = 1'b1;
      step(12);
      fault_raw_i = 1'b0;
      step(1);
      fault_raw_i = 1'b1;
      step(12);
      chk("R8", "interrupted fault not accepted", 3'b100);
      step(30);
      chk("R8", "continuous fault accepted", 3'b010);
      fault_raw_i = 1'b0;
      do_clear();
      step(4);
      chk("R1", "idle at end", 3'b100);

      finish_run();
   end

endmodule